// File: doc/BRIEF.md
# Dual-Role USB Control and Interrupt Register Block

This block is the software-visible register file of a dual-role (host or peripheral) USB controller. A 32-bit register bus with a byte address, a write strobe, write data and combinational read data reaches five word registers: a control word, a PHY control word, an interrupt enable word, a write-1-to-clear interrupt status word and a read-only live status word. The analog comparators, the PHY and the data path sit outside; what comes in are the raw line-status bits (ID, session end, B-session valid, A-session valid, VBUS valid), the power-switch status pin, the current state of the role state machine and three event pulses from it.

Line-status bits pass through a two-flop synchroniser and an edge detector, so each one raises its own change flag on either edge. State transitions of the role machine raise flags for entering host, entering peripheral, swapping role, entering the VBUS-error state and returning to idle, and they clear the request bits in the control word without software help. One registered interrupt line carries the OR of all enabled flags, and the external VBUS power switch is driven through a programmable-polarity enable pin.

Top module: `dualrole_regs`

## Requirements
- R1: After reset every register reads zero, the status word reads zero with all line inputs low and the role input at a_idle (code 0), and both irq_o and vbus_en_o are low.
- R2: Word decode uses byte offsets 0x00 control, 0x04 PHY control, 0x08 interrupt enable, 0x0C interrupt status, 0x10 status; control keeps bits 0 (VBUS drop), 1 (bus request), 2 (role-swap enable), 4 (dual-role enable), 5 (ID wake enable) with bit 3 reading zero; PHY control keeps bits 0 (PHY enable), 1 (ID detect enable), 4 (enable polarity), 5 (switch status polarity); interrupt enable keeps bits 0 to 11 and 13; any other offset reads zero.
- R3: The bus-request bit clears on a control write with bit 0 set (same write), on a detected ID change, on entry to a_wait_vfall (code 6) and on an srp_fail_i pulse; such a clear takes priority over a software write setting it in the same cycle.
- R4: The role-swap enable bit clears when the role moves from a_suspend (4) to a_peripheral (5), from b_peripheral (10) to b_wait_acon (11), or into a_idle (0) or b_idle (8) from any other code.
- R5: Each line input passes two synchroniser flops; its live value appears in the status word after two clock edges and its change flag (ID bit 5, B-valid bit 8, A-valid bit 9, VBUS-valid bit 10, session-end bit 11) sets on the third edge, for rising and falling changes alike.
- R6: While PHY control bit 1 is 0, an ID change raises no flag and leaves the bus-request bit alone; the live ID still shows in status bit 1.
- R7: Writing 1 to an interrupt status bit clears it, writing 0 leaves it, and a hardware set in the same cycle as a clear leaves the bit set; bit 12 always reads 0.
- R8: Role events set: bit 0 on a host/peripheral swap, bit 1 on entry to a_vbus_err (7), bit 4 on entry to a_idle or b_idle, bit 6 on entry to a peripheral code (5, 10), bit 7 on entry to a host code (3, 4, 12); pulses srp_fail_i, hnp_fail_i, srp_det_i set bits 2, 3, 13. Other codes: 1 a_wait_vrise, 2 a_wait_bcon, 9 b_srp_init.
- R9: The status word shows bit 0 over-current (in a_vbus_err, or VBUS driven while the corrected switch status is low), bit 1 ID, bit 2 session end, bit 3 B-valid, bit 4 A-valid, bit 5 VBUS valid, bit 6 peripheral role, bit 7 host role.
- R10: irq_o is a register loaded each cycle with the OR of interrupt status AND enable, so it follows a flag change by one clock.
- R11: VBUS is driven when dual-role enable and bus request are 1 and live ID is 0; vbus_en_o equals that drive value XOR PHY control bit 4, and the switch status pin is taken XOR PHY control bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr |
| id_i | input | 1 | Raw ID line (0 = A plug) |
| sess_end_i | input | 1 | Raw session-end comparator |
| bvalid_i | input | 1 | Raw B-session valid |
| avalid_i | input | 1 | Raw A-session valid |
| vbus_valid_i | input | 1 | Raw VBUS valid |
| pwr_stat_i | input | 1 | Raw power-switch status pin |
| role_i | input | 4 | Current role state code |
| srp_fail_i | input | 1 | Session-request failure pulse |
| hnp_fail_i | input | 1 | Role-swap failure pulse |
| srp_det_i | input | 1 | Session request detected pulse |
| irq_o | output | 1 | Combined registered interrupt |
| vbus_en_o | output | 1 | Power-switch enable pin |

## Verification
Two pairs of functions can land on one clock edge: a hardware flag set against a software write-1-to-clear of the same status bit, and a hardware clear of the bus-request bit against a software write that sets it. The bench provokes both by raising srp_fail_i or hnp_fail_i in the very cycle that carries the conflicting bus write. It judges the result by reading back that the flag stayed set and that the bus-request bit ended cleared, then clears the flag and confirms that a lone write of 1 does clear it.

// File: rtl/drc_pkg.sv
package drc_pkg;
  localparam int OFS_CTRL = 'h00;
  localparam int OFS_PHY  = 'h04;
  localparam int OFS_IEN  = 'h08;
  localparam int OFS_ISTS = 'h0C;
  localparam int OFS_STAT = 'h10;

  localparam int INT_W = 14;
  localparam logic [INT_W-1:0] INT_MASK = 14'h2FFF;

  localparam int IB_SWAP = 0;
  localparam int IB_VERR = 1;
  localparam int IB_SRPF = 2;
  localparam int IB_HNPF = 3;
  localparam int IB_IDLE = 4;
  localparam int IB_ID   = 5;
  localparam int IB_PERI = 6;
  localparam int IB_HOST = 7;
  localparam int IB_BV   = 8;
  localparam int IB_AV   = 9;
  localparam int IB_VV   = 10;
  localparam int IB_SE   = 11;
  localparam int IB_SRPD = 13;

  localparam int LN_W   = 6;
  localparam int LN_ID  = 0;
  localparam int LN_SE  = 1;
  localparam int LN_BV  = 2;
  localparam int LN_AV  = 3;
  localparam int LN_VV  = 4;
  localparam int LN_PWR = 5;

  typedef enum logic [3:0] {
    RS_A_IDLE   = 4'd0,  RS_A_VRISE  = 4'd1,  RS_A_BCON  = 4'd2,
    RS_A_HOST   = 4'd3,  RS_A_SUSP   = 4'd4,  RS_A_PERI  = 4'd5,
    RS_A_VFALL  = 4'd6,  RS_A_VERR   = 4'd7,  RS_B_IDLE  = 4'd8,
    RS_B_SRP    = 4'd9,  RS_B_PERI   = 4'd10, RS_B_ACON  = 4'd11,
    RS_B_HOST   = 4'd12
  } role_e;

  function automatic logic f_is_host(input role_e r);
    return (r == RS_A_HOST) || (r == RS_A_SUSP) || (r == RS_B_HOST);
  endfunction

  function automatic logic f_is_peri(input role_e r);
    return (r == RS_A_PERI) || (r == RS_B_PERI);
  endfunction

  function automatic logic f_is_idle(input role_e r);
    return (r == RS_A_IDLE) || (r == RS_B_IDLE);
  endfunction

  // Next value of one sticky flag: a set beats a clear.
  function automatic logic f_flag_next(input logic cur, input logic clr, input logic set);
    return set | (cur & ~clr);
  endfunction
endpackage

// File: rtl/drc_line_sync.sv
module drc_line_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] live_o,
  output logic [W-1:0] edge_o
);
  localparam int CHAIN = STAGES + 1;

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [CHAIN-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[CHAIN-2:0], raw_i[b]};
    end
    assign live_o[b] = chain_q[STAGES-1];
    assign edge_o[b] = chain_q[STAGES-1] ^ chain_q[STAGES];
  end
endmodule

// File: rtl/drc_role_track.sv
module drc_role_track import drc_pkg::*; (
  input  logic  clk,
  input  logic  rst_n,
  input  role_e role_i,
  output logic  ev_idle,
  output logic  ev_host,
  output logic  ev_peri,
  output logic  ev_swap,
  output logic  ev_verr,
  output logic  ev_vfall,
  output logic  ev_hnp_clr,
  output logic  is_host,
  output logic  is_peri,
  output logic  in_verr
);
  role_e prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RS_A_IDLE;
    else        prev_q <= role_i;
  end

  assign is_host  = f_is_host(role_i);
  assign is_peri  = f_is_peri(role_i);
  assign in_verr  = (role_i == RS_A_VERR);

  assign ev_idle  = f_is_idle(role_i) && !f_is_idle(prev_q);
  assign ev_host  = f_is_host(role_i) && !f_is_host(prev_q);
  assign ev_peri  = f_is_peri(role_i) && !f_is_peri(prev_q);
  assign ev_swap  = (f_is_host(prev_q) && f_is_peri(role_i)) ||
                    (f_is_peri(prev_q) && f_is_host(role_i));
  assign ev_verr  = in_verr && (prev_q != RS_A_VERR);
  assign ev_vfall = (role_i == RS_A_VFALL) && (prev_q != RS_A_VFALL);
  assign ev_hnp_clr = ev_idle ||
                      ((prev_q == RS_A_SUSP) && (role_i == RS_A_PERI)) ||
                      ((prev_q == RS_B_PERI) && (role_i == RS_B_ACON));

  // R8: a role swap is always also an entry into host or peripheral
  a_r8_swap_is_entry: assert property (@(posedge clk) disable iff (!rst_n)
    ev_swap |-> (ev_host || ev_peri));
endmodule

// File: rtl/drc_int_status.sv
module drc_int_status import drc_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [INT_W-1:0] set_i,
  input  logic             clr_wr_i,
  input  logic [INT_W-1:0] clr_data_i,
  input  logic [INT_W-1:0] ien_i,
  output logic [INT_W-1:0] sts_o,
  output logic             irq_o
);
  logic [INT_W-1:0] sts_q;
  logic             irq_q;

  for (genvar k = 0; k < INT_W; k++) begin : g_flag
    if (INT_MASK[k]) begin : g_live
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sts_q[k] <= 1'b0;
        else        sts_q[k] <= f_flag_next(sts_q[k], clr_wr_i & clr_data_i[k], set_i[k]);
      end
      // R7: a hardware set survives any same-cycle clear
      a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i[k] |=> sts_q[k]);
      // R7: writing 0 to a set flag keeps it
      a_r7_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr_i && !clr_data_i[k] && sts_q[k]) |=> sts_q[k]);
    end else begin : g_hole
      assign sts_q[k] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(sts_q & ien_i);
  end

  assign sts_o = sts_q;
  assign irq_o = irq_q;

  // R10: an enabled pending flag drives the line on the next edge
  a_r10_irq_raise: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts_q & ien_i) != '0) |=> irq_o);
endmodule

// File: rtl/dualrole_regs.sv
module dualrole_regs import drc_pkg::*; #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              id_i,
  input  logic              sess_end_i,
  input  logic              bvalid_i,
  input  logic              avalid_i,
  input  logic              vbus_valid_i,
  input  logic              pwr_stat_i,
  input  logic [3:0]        role_i,
  input  logic              srp_fail_i,
  input  logic              hnp_fail_i,
  input  logic              srp_det_i,
  output logic              irq_o,
  output logic              vbus_en_o
);
  localparam int WSEL_W = ADDR_W - 2;

  // ---------------- address decode ----------------
  logic              aligned;
  logic [WSEL_W-1:0] wsel;
  logic              wr_ctrl, wr_phy, wr_ien, wr_ists;

  assign aligned = (bus_addr[1:0] == 2'b00);
  assign wsel    = bus_addr[ADDR_W-1:2];
  assign wr_ctrl = bus_wr && aligned && (wsel == WSEL_W'(OFS_CTRL / 4));
  assign wr_phy  = bus_wr && aligned && (wsel == WSEL_W'(OFS_PHY / 4));
  assign wr_ien  = bus_wr && aligned && (wsel == WSEL_W'(OFS_IEN / 4));
  assign wr_ists = bus_wr && aligned && (wsel == WSEL_W'(OFS_ISTS / 4));

  logic unused_wdata_hi;
  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:INT_W];

  // ---------------- line synchroniser ----------------
  logic [LN_W-1:0] lines_raw, live, line_edge;
  assign lines_raw = {pwr_stat_i, vbus_valid_i, avalid_i, bvalid_i, sess_end_i, id_i};

  drc_line_sync #(.W(LN_W), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_i(lines_raw), .live_o(live), .edge_o(line_edge)
  );

  // ---------------- role tracking ----------------
  logic ev_idle, ev_host, ev_peri, ev_swap, ev_verr, ev_vfall, ev_hnp_clr;
  logic is_host, is_peri, in_verr;

  drc_role_track u_role (
    .clk(clk), .rst_n(rst_n), .role_i(role_e'(role_i)),
    .ev_idle(ev_idle), .ev_host(ev_host), .ev_peri(ev_peri), .ev_swap(ev_swap),
    .ev_verr(ev_verr), .ev_vfall(ev_vfall), .ev_hnp_clr(ev_hnp_clr),
    .is_host(is_host), .is_peri(is_peri), .in_verr(in_verr)
  );

  // ---------------- PHY control ----------------
  logic phy_en_q, id_det_q, en_pol_q, st_pol_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phy_en_q <= 1'b0; id_det_q <= 1'b0; en_pol_q <= 1'b0; st_pol_q <= 1'b0;
    end else if (wr_phy) begin
      phy_en_q <= bus_wdata[0];
      id_det_q <= bus_wdata[1];
      en_pol_q <= bus_wdata[4];
      st_pol_q <= bus_wdata[5];
    end
  end

  // Named event wires for the checks below
  logic id_chg_ev, req_clr_ev;
  assign id_chg_ev  = line_edge[LN_ID] & id_det_q;
  assign req_clr_ev = id_chg_ev | ev_vfall | srp_fail_i;

  // ---------------- control word ----------------
  logic drop_q, busreq_q, hnp_q, dr_en_q, wake_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drop_q <= 1'b0; busreq_q <= 1'b0; hnp_q <= 1'b0; dr_en_q <= 1'b0; wake_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        drop_q  <= bus_wdata[0];
        dr_en_q <= bus_wdata[4];
        wake_q  <= bus_wdata[5];
      end
      if (req_clr_ev)   busreq_q <= 1'b0;
      else if (wr_ctrl) busreq_q <= bus_wdata[1] & ~bus_wdata[0];
      if (ev_hnp_clr)   hnp_q <= 1'b0;
      else if (wr_ctrl) hnp_q <= bus_wdata[2];
    end
  end

  // ---------------- interrupt enable ----------------
  logic [INT_W-1:0] ien_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ien_q <= '0;
    else if (wr_ien) ien_q <= bus_wdata[INT_W-1:0] & INT_MASK;
  end

  // ---------------- interrupt status ----------------
  logic [INT_W-1:0] sts_set, ists;
  always_comb begin
    sts_set           = '0;
    sts_set[IB_SWAP]  = ev_swap;
    sts_set[IB_VERR]  = ev_verr;
    sts_set[IB_SRPF]  = srp_fail_i;
    sts_set[IB_HNPF]  = hnp_fail_i;
    sts_set[IB_IDLE]  = ev_idle;
    sts_set[IB_ID]    = id_chg_ev;
    sts_set[IB_PERI]  = ev_peri;
    sts_set[IB_HOST]  = ev_host;
    sts_set[IB_BV]    = line_edge[LN_BV];
    sts_set[IB_AV]    = line_edge[LN_AV];
    sts_set[IB_VV]    = line_edge[LN_VV];
    sts_set[IB_SE]    = line_edge[LN_SE];
    sts_set[IB_SRPD]  = srp_det_i;
  end

  drc_int_status u_ists (
    .clk(clk), .rst_n(rst_n), .set_i(sts_set), .clr_wr_i(wr_ists),
    .clr_data_i(bus_wdata[INT_W-1:0]), .ien_i(ien_q), .sts_o(ists), .irq_o(irq_o)
  );

  // ---------------- power switch ----------------
  logic vbus_drive, pwr_ok, over_cur;
  assign vbus_drive = dr_en_q & busreq_q & ~live[LN_ID];
  assign pwr_ok     = live[LN_PWR] ^ st_pol_q;
  assign over_cur   = in_verr | (vbus_drive & ~pwr_ok);
  assign vbus_en_o  = vbus_drive ^ en_pol_q;

  // ---------------- read mux ----------------
  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      case (wsel)
        WSEL_W'(OFS_CTRL / 4): bus_rdata = DATA_W'({wake_q, dr_en_q, 1'b0, hnp_q, busreq_q, drop_q});
        WSEL_W'(OFS_PHY / 4):  bus_rdata = DATA_W'({st_pol_q, en_pol_q, 2'b00, id_det_q, phy_en_q});
        WSEL_W'(OFS_IEN / 4):  bus_rdata = DATA_W'(ien_q);
        WSEL_W'(OFS_ISTS / 4): bus_rdata = DATA_W'(ists);
        WSEL_W'(OFS_STAT / 4): bus_rdata = DATA_W'({is_host, is_peri, live[LN_VV], live[LN_AV],
                                                   live[LN_BV], live[LN_SE], live[LN_ID], over_cur});
        default:               bus_rdata = '0;
      endcase
    end
  end

  // ---------------- assertions ----------------
  // R3: a write with the drop bit set leaves no bus request behind
  a_r3_drop_clears_req: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && bus_wdata[0]) |=> !busreq_q);
  // R3: hardware clear events beat any software set
  a_r3_event_clears_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_clr_ev |=> !busreq_q);
  // R4: the four role transitions remove the role-swap enable
  a_r4_hnp_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hnp_clr |=> !hnp_q);
  // R6: with ID detection off the ID flag cannot rise
  a_r6_id_flag_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!id_det_q && !ists[IB_ID]) |=> !ists[IB_ID]);
endmodule

// File: tb/dualrole_regs_bench.sv
module dualrole_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        id_i = 0, sess_end_i = 0, bvalid_i = 0, avalid_i = 0, vbus_valid_i = 0, pwr_stat_i = 0;
  logic [3:0]  role_i = 4'd0;
  logic        srp_fail_i = 0, hnp_fail_i = 0, srp_det_i = 0;
  logic        irq_o, vbus_en_o;

  always #5 clk = ~clk;

  dualrole_regs u_dualrole_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .id_i(id_i), .sess_end_i(sess_end_i), .bvalid_i(bvalid_i),
    .avalid_i(avalid_i), .vbus_valid_i(vbus_valid_i), .pwr_stat_i(pwr_stat_i), .role_i(role_i),
    .srp_fail_i(srp_fail_i), .hnp_fail_i(hnp_fail_i), .srp_det_i(srp_det_i),
    .irq_o(irq_o), .vbus_en_o(vbus_en_o)
  );

  localparam logic [4:0] A_CTL = 5'h00, A_PHY = 5'h04, A_IEN = 5'h08, A_IST = 5'h0C, A_STA = 5'h10;

  typedef struct {
    int          kind;   // 0 read data, 1 irq pin, 2 vbus enable pin
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t exp_q[$];
  int    checks = 0;
  int    errors = 0;
  bit    done = 0;

  // Monitor: pops expectations and compares against the ports
  always @(negedge clk) begin
    item_t       it;
    logic [31:0] act;
    #2;
    while (exp_q.size() > 0) begin
      it = exp_q.pop_front();
      case (it.kind)
        0:       act = bus_rdata;
        1:       act = {31'b0, irq_o};
        default: act = {31'b0, vbus_en_o};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  // Driver tasks
  task automatic chk(input logic [4:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk); #1;
    bus_addr = a;
    it.kind = 0; it.exp = e; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic chk_pin(input int kind, input logic e, input string tag);
    item_t it;
    @(negedge clk); @(negedge clk); #1;
    it.kind = kind; it.exp = {31'b0, e}; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic set_role(input logic [3:0] r);
    @(negedge clk);
    role_i = r;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk(A_CTL, 32'h0, "R1 ctrl");
    chk(A_PHY, 32'h0, "R1 phy");
    chk(A_IEN, 32'h0, "R1 ien");
    chk(A_IST, 32'h0, "R1 ists");
    chk(A_STA, 32'h0, "R1 status");
    chk_pin(1, 1'b0, "R1 irq");
    chk_pin(2, 1'b0, "R1 vbus_en");

    // R2 decode and field widths
    wr(A_IEN, 32'hFFFF_FFFF); chk(A_IEN, 32'h2FFF, "R2 ien bits");
    wr(A_PHY, 32'hFFFF_FFFF); chk(A_PHY, 32'h33, "R2 phy bits");
    wr(A_CTL, 32'h3E);        chk(A_CTL, 32'h36, "R2 ctrl bit3 zero");
    chk(5'h14, 32'h0, "R2 unmapped");

    // R11 power switch polarity
    wr(A_PHY, 32'h03);
    chk_pin(2, 1'b1, "R11 vbus_en active high");
    chk(A_STA, 32'h01, "R9 over-current switch low");
    @(negedge clk); pwr_stat_i = 1'b1;
    idle(3);
    chk(A_STA, 32'h00, "R11 switch ok");
    wr(A_PHY, 32'h23); chk(A_STA, 32'h01, "R11 status polarity inverted");
    wr(A_PHY, 32'h13); chk_pin(2, 1'b0, "R11 vbus_en active low");
    chk(A_STA, 32'h00, "R11 switch ok normal");
    wr(A_PHY, 32'h03);

    // R3 bus request clears
    wr(A_CTL, 32'h37); chk(A_CTL, 32'h35, "R3 drop clears request");
    chk_pin(2, 1'b0, "R3 vbus off after drop");
    wr(A_CTL, 32'h36);
    set_role(4'd6);    chk(A_CTL, 32'h34, "R3 a_wait_vfall clears request");
    set_role(4'd0);    chk(A_CTL, 32'h30, "R4 return to a_idle clears swap enable");
    chk(A_IST, 32'h10, "R8 idle entry flag");
    chk_pin(1, 1'b1, "R10 irq raised");
    wr(A_IST, 32'h10); chk(A_IST, 32'h0, "R7 clear idle flag");
    chk_pin(1, 1'b0, "R10 irq dropped");
    wr(A_CTL, 32'h36);
    @(negedge clk); srp_fail_i = 1'b1; @(posedge clk); #1; srp_fail_i = 1'b0;
    chk(A_CTL, 32'h34, "R3 srp failure clears request");
    chk(A_IST, 32'h04, "R8 srp fail flag");
    wr(A_IST, 32'h04);
    wr(A_CTL, 32'h36);
    @(negedge clk); id_i = 1'b1;
    idle(4);
    chk(A_CTL, 32'h34, "R3 id change clears request");
    chk(A_IST, 32'h20, "R5 id change flag");
    chk(A_STA, 32'h02, "R9 id live");
    wr(A_IST, 32'h20);

    // R6 ID detection disabled
    wr(A_PHY, 32'h01);
    wr(A_CTL, 32'h36);
    @(negedge clk); id_i = 1'b0;
    idle(4);
    chk(A_IST, 32'h0, "R6 no id flag");
    chk(A_CTL, 32'h36, "R6 request kept");
    chk(A_STA, 32'h00, "R6 live id still shown");
    wr(A_PHY, 32'h03);

    // R5 synchroniser latency and both edges
    @(negedge clk); sess_end_i = 1'b1;
    chk(A_STA, 32'h00, "R5 not yet visible after one edge");
    chk(A_IST, 32'h0, "R5 no flag after two edges");
    chk(A_IST, 32'h800, "R5 session end rise flag on third edge");
    wr(A_IST, 32'h800);
    @(negedge clk); sess_end_i = 1'b0;
    idle(4);
    chk(A_IST, 32'h800, "R5 session end fall flag");
    wr(A_IST, 32'h800);
    @(negedge clk); bvalid_i = 1'b1; avalid_i = 1'b1; vbus_valid_i = 1'b1;
    idle(4);
    chk(A_IST, 32'h700, "R5 valid line flags");
    chk(A_STA, 32'h38, "R9 valid lines live");
    wr(A_IST, 32'h200); chk(A_IST, 32'h500, "R7 partial clear");
    wr(A_IST, 32'h0);   chk(A_IST, 32'h500, "R7 zero write keeps");
    wr(A_IST, 32'h500);

    // R4 / R8 role transitions
    set_role(4'd3); chk(A_IST, 32'h80, "R8 host entry");
    set_role(4'd4);
    set_role(4'd5); chk(A_CTL, 32'h32, "R4 suspend to peripheral clears swap enable");
    chk(A_IST, 32'hC1, "R8 swap and peripheral entry");
    chk(A_STA, 32'h78, "R9 peripheral role");
    wr(A_IST, 32'hC1);
    wr(A_CTL, 32'h36);
    set_role(4'd10);
    set_role(4'd11); chk(A_CTL, 32'h32, "R4 b_peripheral to b_wait_acon clears");
    chk(A_IST, 32'h0, "R8 no flags on peripheral exit");
    wr(A_CTL, 32'h36);
    set_role(4'd8);  chk(A_CTL, 32'h32, "R4 b_idle clears swap enable");
    chk(A_IST, 32'h10, "R8 b_idle entry");
    wr(A_IST, 32'h10);
    set_role(4'd7);  chk(A_IST, 32'h02, "R8 vbus error entry");
    chk(A_STA, 32'h39, "R9 over-current in error state");
    set_role(4'd0);  chk(A_IST, 32'h12, "R8 back to a_idle");
    wr(A_IST, 32'h12);

    // R7 / R3 same-cycle conflicts
    @(negedge clk);
    bus_addr = A_IST; bus_wdata = 32'h08; bus_wr = 1'b1; hnp_fail_i = 1'b1;
    @(posedge clk); #1; bus_wr = 1'b0; hnp_fail_i = 1'b0;
    chk(A_IST, 32'h08, "R7 set beats clear");
    wr(A_IST, 32'h08); chk(A_IST, 32'h0, "R7 lone clear");
    @(negedge clk);
    bus_addr = A_CTL; bus_wdata = 32'h36; bus_wr = 1'b1; srp_fail_i = 1'b1;
    @(posedge clk); #1; bus_wr = 1'b0; srp_fail_i = 1'b0;
    chk(A_CTL, 32'h34, "R3 hardware clear beats write");
    chk(A_IST, 32'h04, "R8 srp fail with write");
    wr(A_IST, 32'h04);

    // R10 enable gating
    wr(A_IEN, 32'h0);
    @(negedge clk); srp_det_i = 1'b1; @(posedge clk); #1; srp_det_i = 1'b0;
    chk(A_IST, 32'h2000, "R8 srp detected flag");
    chk_pin(1, 1'b0, "R10 masked flag no irq");
    wr(A_IEN, 32'h2000); chk_pin(1, 1'b1, "R10 enable raises irq");
    wr(A_IST, 32'h2000); chk_pin(1, 1'b0, "R10 clear drops irq");

    idle(3);
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule